// File: doc/BRIEF.md
# Core Clock-Enable Generator with Glitch-Free Rate Switch

This block produces the clock-enable pulses that pace the core and the peripherals of an 8-bit microcontroller from a single crystal-rate clock. In standard mode a divide-by-two stage sits in front of the core's phase sequencer, so the enable fires on every second input cycle. In double-speed mode the stage is bypassed and the enable fires on every input cycle. Everything stays in the one input clock domain. No second clock net is gated or multiplexed.

Software selects the rate by writing a mode bit through a one-bit write port. The written value is held as a request. It is copied into the active mode only at a rising edge of the halved clock, so a change in either direction can never shorten or stretch an enable pulse. A six-state phase sequencer advances on every enabled cycle and raises a machine-cycle strobe when it wraps. A machine cycle therefore lasts 12 input clocks in standard mode and 6 in double-speed mode.

Top module: `xtal_ce_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `core_ce` and `mcyc_stb` are low. After reset the block is in standard mode, with the toggle and the phase at zero. The first `mcyc_stb` comes 11 cycles after the cycle in which `rst` falls.
- R2: In standard mode `core_ce` is high on alternate cycles, namely the cycles in which the internal halving toggle is 1. That is cycle 1, 3, 5, … counted from the cycle in which `rst` falls.
- R3: In double-speed mode `core_ce` is high on every cycle.
- R4: A write (`cfg_wr`=1, `cfg_fast`=1 for double speed, 0 for standard) updates the requested mode at that clock edge. The active mode copies the request only at an edge that ends a cycle with the toggle at 0. The new rate therefore first shows 2 or 3 cycles after the write cycle, always in a cycle where the toggle is 1.
- R5: `core_ce` is never low in two consecutive cycles, including across mode changes. The gap between two enable pulses is therefore always 1 or 2 cycles.
- R6: `periph_ce` equals `core_ce` in every cycle.
- R7: The phase advances by one on each cycle with `core_ce` high and wraps from 5 to 0. `mcyc_stb` is high in the enabled cycle whose phase is 5. In steady mode the strobe period is 6 cycles in double-speed mode and 12 cycles in standard mode.
- R8: A write that repeats the current requested mode changes neither the enable pattern nor the strobe timing.
- R9: `mcyc_stb` is high only in cycles where `core_ce` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-rate input clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the mode bit |
| cfg_fast | input | 1 | Mode value written: 1 double speed, 0 standard |
| core_ce | output | 1 | Core clock enable |
| periph_ce | output | 1 | Peripheral clock enable |
| mcyc_stb | output | 1 | One-cycle machine-cycle strobe at phase wrap |

## Verification
The assertions assume that `rst` is held high for at least two clock edges before release. This ensures that every `$past` value they read already reflects the reset state. They also assume that `cfg_wr` and `cfg_fast` are synchronous and never unknown. The stimulus holds reset for four cycles and drives the write port only at the falling clock edge. Beyond that, writes are left unconstrained: they land at both toggle parities, sometimes on back-to-back cycles and sometimes with a value that repeats the current request. This exercises every alignment of a write with the halved-clock edge.

// File: rtl/xce_pkg.sv
package xce_pkg;

    typedef enum logic {
        MODE_STD = 1'b0,
        MODE_DBL = 1'b1
    } clk_mode_e;

    typedef struct packed {
        logic      half;
        clk_mode_e req;
        clk_mode_e act;
    } div_state_t;

    localparam div_state_t DIV_RESET = '{half: 1'b0, req: MODE_STD, act: MODE_STD};

    // The halved clock rises at the edge that ends a cycle with the toggle low.
    function automatic logic half_rise(logic half);
        return !half;
    endfunction

    function automatic logic enable_of(div_state_t s);
        return (s.act == MODE_DBL) || s.half;
    endfunction

endpackage

// File: rtl/xce_divider.sv
module xce_divider
    import xce_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic      wr_mode,
    output logic      core_ce,
    output logic      div_tgl,
    output clk_mode_e mode_act
);

    div_state_t st_q;
    div_state_t st_d;

    always_comb begin
        st_d      = st_q;
        st_d.half = ~st_q.half;
        if (wr_en) begin
            st_d.req = clk_mode_e'(wr_mode);
        end
        if (half_rise(st_q.half)) begin
            st_d.act = st_q.req;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= DIV_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign core_ce  = enable_of(st_q);
    assign div_tgl  = st_q.half;
    assign mode_act = st_q.act;

endmodule

// File: rtl/xce_phase_seq.sv
module xce_phase_seq #(
    parameter int PHASES  = 6,
    parameter int PHASE_W = $clog2(PHASES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ce,
    output logic [PHASE_W-1:0] phase,
    output logic               stb
);

    localparam logic [PHASE_W-1:0] LAST = PHASE_W'(PHASES - 1);

    logic               at_last;
    logic [PHASE_W-1:0] nxt;

    assign at_last = (phase == LAST);

    generate
        if ((1 << PHASE_W) == PHASES) begin : g_pow2
            assign nxt = phase + 1'b1;
        end else begin : g_cmp
            assign nxt = at_last ? '0 : phase + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (ce) begin
            phase <= nxt;
        end
    end

    assign stb = ce && at_last;

endmodule

// File: rtl/xtal_ce_gen.sv
module xtal_ce_gen
    import xce_pkg::*;
#(
    parameter int PHASES = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_wr,
    input  logic cfg_fast,
    output logic core_ce,
    output logic periph_ce,
    output logic mcyc_stb
);

    localparam int PHASE_W = $clog2(PHASES);

    logic               div_tgl;
    clk_mode_e          mode_act;
    logic [PHASE_W-1:0] phase;

    xce_divider u_div (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr),
        .wr_mode  (cfg_fast),
        .core_ce  (core_ce),
        .div_tgl  (div_tgl),
        .mode_act (mode_act)
    );

    xce_phase_seq #(
        .PHASES  (PHASES),
        .PHASE_W (PHASE_W)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .ce    (core_ce),
        .phase (phase),
        .stb   (mcyc_stb)
    );

    // Peripherals run from the same (halved or full-rate) enable as the core.
    assign periph_ce = core_ce;

endmodule

// File: rtl/xtal_ce_gen_chk.sv
module xtal_ce_gen_chk #(
    parameter int PHASES  = 6,
    parameter int PHASE_W = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               core_ce,
    input logic               mcyc_stb,
    input logic               mode_act,
    input logic               div_tgl,
    input logic [PHASE_W-1:0] phase
);

    localparam logic [PHASE_W-1:0] LAST = PHASE_W'(PHASES - 1);

    assert_no_double_gap_R5: assert property (@(posedge clk) disable iff (rst)
        !core_ce |=> core_ce)
        else $error("R5: enable low in two consecutive cycles");

    assert_stb_on_ce_R9: assert property (@(posedge clk) disable iff (rst)
        mcyc_stb |-> core_ce)
        else $error("R9: strobe without enable");

    assert_phase_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !core_ce |=> $stable(phase))
        else $error("R7: phase moved without enable");

    assert_phase_step_R7: assert property (@(posedge clk) disable iff (rst)
        (core_ce && phase != LAST) |=> phase == PHASE_W'($past(phase) + 1'b1))
        else $error("R7: phase did not advance by one");

    assert_phase_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        mcyc_stb |=> phase == '0)
        else $error("R7: phase did not wrap after strobe");

    assert_mode_edge_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_act) |-> $past(div_tgl) == 1'b0)
        else $error("R4: mode changed away from a halved-clock rising edge");

endmodule

bind xtal_ce_gen xtal_ce_gen_chk #(
    .PHASES  (PHASES),
    .PHASE_W (PHASE_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .core_ce  (core_ce),
    .mcyc_stb (mcyc_stb),
    .mode_act (mode_act),
    .div_tgl  (div_tgl),
    .phase    (phase)
);

// File: tb/xtal_ce_gen_tb.sv
module xtal_ce_gen_tb;

    localparam int PHASES = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wr = 1'b0;
    logic cfg_fast = 1'b0;
    logic core_ce, periph_ce, mcyc_stb;

    always #5 clk = ~clk;

    xtal_ce_gen #(.PHASES(PHASES)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_fast  (cfg_fast),
        .core_ce   (core_ce),
        .periph_ce (periph_ce),
        .mcyc_stb  (mcyc_stb)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // requirement-level model state
    logic m_tgl, m_req, m_act;
    int   m_ph;
    int   cyc = 0;
    int   last_ce = -1;
    int   last_stb = -1;
    int   first_stb = -1;
    int   last_chg = 0;
    bit   in_r8 = 0;

    function automatic logic exp_ce(logic act, logic tgl);
        return act | tgl;
    endfunction

    function automatic logic exp_stb(logic ce, int ph);
        return ce && (ph == PHASES - 1);
    endfunction

    function automatic int exp_period(logic act);
        return act ? PHASES : 2 * PHASES;
    endfunction

    task automatic chk_bit(string req, string what, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: got %0b expected %0b", req, what, cyc, got, exp);
        end
    endtask

    task automatic chk_int(string req, string what, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: got %0d expected %0d", req, what, cyc, got, exp);
        end
    endtask

    // effect of one rising edge on the model, given the inputs of the cycle
    task automatic model_edge(logic w, logic v);
        logic ce;
        ce = exp_ce(m_act, m_tgl);
        if (!m_tgl) begin
            if (m_act != m_req) last_chg = cyc + 1;
            m_act = m_req;
        end
        if (w) m_req = v;
        if (ce) m_ph = (m_ph == PHASES - 1) ? 0 : m_ph + 1;
        m_tgl = ~m_tgl;
    endtask

    task automatic observe();
        logic  e_ce;
        string tag;
        e_ce = exp_ce(m_act, m_tgl);
        if (cyc - last_chg < 2) tag = "R4";
        else if (in_r8)         tag = "R8";
        else                    tag = m_act ? "R3" : "R2";
        chk_bit(tag, "core_ce", core_ce, e_ce);
        chk_bit("R6", "periph_ce", periph_ce, core_ce);
        chk_bit("R7", "mcyc_stb", mcyc_stb, exp_stb(e_ce, m_ph));
        if (mcyc_stb) chk_bit("R9", "enable under strobe", core_ce, 1'b1);
        if (core_ce) begin
            if (last_ce >= 0) begin
                n_chk++;
                if (cyc - last_ce > 2 || cyc - last_ce < 1) begin
                    n_fail++;
                    $display("FAIL R5 enable gap at cycle %0d: got %0d expected 1 or 2", cyc, cyc - last_ce);
                end
            end
            last_ce = cyc;
        end
        if (mcyc_stb) begin
            if (first_stb < 0) first_stb = cyc;
            if (last_stb >= 0 && last_chg <= last_stb)
                chk_int(in_r8 ? "R8" : "R7", "strobe period", cyc - last_stb, exp_period(m_act));
            last_stb = cyc;
        end
    endtask

    task automatic step(logic w, logic v);
        cfg_wr   = w;
        cfg_fast = v;
        model_edge(w, v);
        @(negedge clk);
        cyc++;
        observe();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk_bit("R1", "core_ce in reset", core_ce, 1'b0);
        chk_bit("R1", "mcyc_stb in reset", mcyc_stb, 1'b0);
        chk_bit("R1", "periph_ce in reset", periph_ce, 1'b0);
        m_tgl = 1'b0; m_req = 1'b0; m_act = 1'b0; m_ph = 0;
        rst = 1'b0;
        idle(30);
        chk_int("R1", "first strobe cycle", first_stb, 11);

        // R4: switch to double speed and back, at both toggle parities
        step(1'b1, 1'b1); idle(30);
        step(1'b1, 1'b0); idle(31);
        step(1'b1, 1'b1); idle(29);
        step(1'b1, 1'b0); idle(30);
        for (int k = 0; k < 16; k++) begin
            step(1'b1, k[0]);
            idle(k % 4);
        end
        idle(30);

        // R8: redundant writes in each steady mode
        step(1'b1, 1'b0); idle(20);
        in_r8 = 1;
        for (int k = 0; k < 40; k++) step(1'b1, 1'b0);
        in_r8 = 0;
        step(1'b1, 1'b1); idle(20);
        in_r8 = 1;
        for (int k = 0; k < 40; k++) step(1'b1, 1'b1);
        in_r8 = 0;
        idle(10);

        // random writes at arbitrary phases
        for (int k = 0; k < 4000; k++) begin
            logic w;
            w = ($urandom % 6) == 0;
            step(w, 1'($urandom % 2));
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d: got timeout expected completion", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule